// File: doc/BRIEF.md
# Local Interrupt Controller Register Decoder

This block is the word-wide register front end of a per-core local interrupt controller. A 12-bit byte address selects one of 256 register slots spaced 16 bytes apart. The block stores the software-visible settings (identity, task priority, spurious-vector word, two command words, six vector-table entries, timer initial count and divide setting). It derives the processor-priority value from the task priority and the in-service array. It reads the in-service, trigger-mode and pending arrays and the timer's current count straight from neighbouring logic.

Two writes have side effects beyond storage. A write to the end-of-interrupt slot raises a one-cycle pulse toward the interrupt tracker. A write to the timer's vector-table entry or to the initial count raises a one-cycle reprogram pulse toward the timer. Any access to a slot that is not defined for that direction sets a sticky error flag, and a read of such a slot returns zero. Reads, writes and the side-effect pins are plain single-cycle strobes with no handshake. The block never stalls, so there is no back-pressure: every strobe is taken in the cycle it is presented.

Top module: `lic_regfile`

## Requirements
- R1: The slot number is address bits [11:4]; address bits [3:0] have no effect on which register is accessed.
- R2: Read data is registered: it appears on `rdata` on the clock edge that samples `rd_en`, and it holds its value in every cycle without a read.
- R3: Slot 0x02 returns the stored identity in bits [31:24] and zeros elsewhere, and a write keeps only write-data bits [31:24]. Slot 0x03 always reads 0x00050011: the value 0x11, with the highest vector-table entry number (5) in bits [23:16].
- R4: Slot 0x08 stores an 8-bit task priority. Slot 0x0A is read-only. It returns the task priority when the task priority's upper nibble is at least the upper nibble of the lowest-numbered set in-service bit (0 if none is set). Otherwise it returns that nibble shifted left by four.
- R5: A write to slot 0x0B drives `eoi_stb` high for exactly the next cycle. A read of slot 0x0B does not pulse it and counts as an undefined access.
- R6: Slot 0x0F keeps only write-data bits [8:0] and resets to 0xFF. Bit 8 of this register drives `sv_enable`.
- R7: Slots 0x10–0x17, 0x18–0x1F and 0x20–0x27 return 32-bit slice n (bits [32n+31:32n]) of the in-service, trigger-mode and pending arrays respectively, where n is the slot number minus the range start.
- R8: Slots 0x30–0x31 (command words), 0x32–0x37 (vector-table entries 0–5) and 0x38 (initial count) store all 32 bits. Every vector-table entry resets to 0x00010000. Slot 0x39 returns `cur_count`. Entry 0 and the initial count appear on `tmr_lvt` and `tmr_init`.
- R9: Slot 0x3E stores write data ANDed with 0xB, and it appears on `tmr_div`.
- R10: A write to slot 0x32 or slot 0x38 drives `tmr_reload` high for exactly the next cycle. Writes to any other slot do not pulse it.
- R11: A read of a slot with no read meaning, or a write to a slot with no write meaning, sets error bit 7 of slot 0x28, and such a read returns zero. The read-only slots are 0x03, 0x0A, 0x10–0x27, 0x28 and 0x39; the write-only slot is 0x0B. The bit stays set until reset.
- R12: When `rd_en` and `wr_en` are both high in one cycle, the read returns the register contents from before that cycle's write and before that cycle's error update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Byte address; bits [11:4] select the slot |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| rdata | output | 32 | Registered read data |
| in_service | input | 256 | In-service array from the tracker |
| trig_mode | input | 256 | Trigger-mode array from the tracker |
| pending | input | 256 | Pending array from the tracker |
| cur_count | input | 32 | Current count from the timer |
| eoi_stb | output | 1 | One-cycle end-of-interrupt pulse |
| tmr_reload | output | 1 | One-cycle timer reprogram pulse |
| tmr_lvt | output | 32 | Vector-table entry 0 (timer) |
| tmr_init | output | 32 | Timer initial count |
| tmr_div | output | 4 | Timer divide setting |
| sv_enable | output | 1 | Software enable bit of the spurious-vector register |

## Verification
A read and a write can land in the same cycle. A combined strobe to the initial-count slot must return the old count while the new one is stored. A combined strobe to the error slot is both a legal read and an illegal write, so the read must show the flag still clear while the same edge sets it. The bench drives both strobes in one cycle and then confirms the old value on `rdata`. It then reads the slot again to see the new value or the set flag. The error flag is also read back after later legal accesses to confirm it does not clear.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int WORD_W = 32;

  // Slot numbers whose position is decoded by software
  localparam logic [7:0] IX_ID   = 8'h02;
  localparam logic [7:0] IX_VER  = 8'h03;
  localparam logic [7:0] IX_TPR  = 8'h08;
  localparam logic [7:0] IX_PPR  = 8'h0A;
  localparam logic [7:0] IX_EOI  = 8'h0B;
  localparam logic [7:0] IX_SVR  = 8'h0F;
  localparam logic [7:0] IX_ISR  = 8'h10;
  localparam logic [7:0] IX_TMR  = 8'h18;
  localparam logic [7:0] IX_IRR  = 8'h20;
  localparam logic [7:0] IX_ESR  = 8'h28;
  localparam logic [7:0] IX_ICR  = 8'h30;
  localparam logic [7:0] IX_LVT  = 8'h32;
  localparam logic [7:0] IX_INIT = 8'h38;
  localparam logic [7:0] IX_CUR  = 8'h39;
  localparam logic [7:0] IX_DIV  = 8'h3E;

  localparam logic [31:0] LVT_RST  = 32'h0001_0000;
  localparam logic [8:0]  SVR_RST  = 9'h0FF;
  localparam logic [3:0]  DIV_MASK = 4'hB;
  localparam int          ERR_BIT  = 7;

  typedef enum logic [3:0] {
    RS_NONE, RS_ID, RS_VER, RS_TPR, RS_PPR, RS_SVR, RS_ISR, RS_TMR,
    RS_IRR, RS_ESR, RS_ICR, RS_LVT, RS_INIT, RS_CUR, RS_DIV
  } rsel_e;

  typedef enum logic [3:0] {
    WT_NONE, WT_ID, WT_TPR, WT_EOI, WT_SVR, WT_ICR, WT_LVT, WT_INIT, WT_DIV
  } wsel_e;
endpackage

// File: rtl/lic_decode.sv
module lic_decode
  import lic_pkg::*;
#(
  parameter int NSLICE = 8,
  parameter int NLVT   = 6
) (
  input  logic [7:0] idx,
  output rsel_e      rsel,
  output wsel_e      wsel,
  output logic [2:0] sub
);
  function automatic logic in_rng(input logic [7:0] v, input logic [7:0] base, input int n);
    return (int'(v) >= int'(base)) && (int'(v) < int'(base) + n);
  endfunction

  always_comb begin
    rsel = RS_NONE;
    wsel = WT_NONE;
    sub  = '0;
    if (idx == IX_ID) begin
      rsel = RS_ID;   wsel = WT_ID;
    end else if (idx == IX_VER) begin
      rsel = RS_VER;
    end else if (idx == IX_TPR) begin
      rsel = RS_TPR;  wsel = WT_TPR;
    end else if (idx == IX_PPR) begin
      rsel = RS_PPR;
    end else if (idx == IX_EOI) begin
      wsel = WT_EOI;
    end else if (idx == IX_SVR) begin
      rsel = RS_SVR;  wsel = WT_SVR;
    end else if (in_rng(idx, IX_ISR, NSLICE)) begin
      rsel = RS_ISR;  sub = 3'(idx - IX_ISR);
    end else if (in_rng(idx, IX_TMR, NSLICE)) begin
      rsel = RS_TMR;  sub = 3'(idx - IX_TMR);
    end else if (in_rng(idx, IX_IRR, NSLICE)) begin
      rsel = RS_IRR;  sub = 3'(idx - IX_IRR);
    end else if (idx == IX_ESR) begin
      rsel = RS_ESR;
    end else if (in_rng(idx, IX_ICR, 2)) begin
      rsel = RS_ICR;  wsel = WT_ICR;  sub = 3'(idx - IX_ICR);
    end else if (in_rng(idx, IX_LVT, NLVT)) begin
      rsel = RS_LVT;  wsel = WT_LVT;  sub = 3'(idx - IX_LVT);
    end else if (idx == IX_INIT) begin
      rsel = RS_INIT; wsel = WT_INIT;
    end else if (idx == IX_CUR) begin
      rsel = RS_CUR;
    end else if (idx == IX_DIV) begin
      rsel = RS_DIV;  wsel = WT_DIV;
    end
  end
endmodule

// File: rtl/lic_prio.sv
module lic_prio #(
  parameter int NVEC = 256
) (
  input  logic [NVEC-1:0] in_service,
  input  logic [7:0]      tpr,
  output logic [7:0]      ppr
);
  logic       hit;
  logic [7:0] top_v;
  logic [3:0] cls;

  // Lowest-numbered set bit is the one currently in service
  always_comb begin
    hit   = 1'b0;
    top_v = '0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (in_service[i]) begin
        hit   = 1'b1;
        top_v = 8'(i);
      end
    end
    cls = hit ? top_v[7:4] : 4'h0;
    ppr = (tpr[7:4] >= cls) ? tpr : {cls, 4'h0};
  end
endmodule

// File: rtl/lic_store.sv
module lic_store
  import lic_pkg::*;
#(
  parameter int NLVT = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  wsel_e              wsel,
  input  logic [2:0]         sub,
  input  logic [31:0]        wdata,
  output logic [7:0]         id_q,
  output logic [7:0]         tpr_q,
  output logic [8:0]         svr_q,
  output logic [63:0]        icr_q,
  output logic [NLVT*32-1:0] lvt_q,
  output logic [31:0]        init_q,
  output logic [3:0]         div_q,
  output logic               eoi_stb,
  output logic               tmr_reload
);
  logic wr_id, wr_tpr, wr_svr, wr_init, wr_div;

  assign wr_id   = wr_en && (wsel == WT_ID);
  assign wr_tpr  = wr_en && (wsel == WT_TPR);
  assign wr_svr  = wr_en && (wsel == WT_SVR);
  assign wr_init = wr_en && (wsel == WT_INIT);
  assign wr_div  = wr_en && (wsel == WT_DIV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_q   <= '0;
      tpr_q  <= '0;
      svr_q  <= SVR_RST;
      init_q <= '0;
      div_q  <= '0;
    end else begin
      if (wr_id)   id_q   <= wdata[31:24];
      if (wr_tpr)  tpr_q  <= wdata[7:0];
      if (wr_svr)  svr_q  <= wdata[8:0];
      if (wr_init) init_q <= wdata;
      if (wr_div)  div_q  <= wdata[3:0] & DIV_MASK;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_icr
    always_ff @(posedge clk) begin
      if (!rst_n)
        icr_q[g*32 +: 32] <= '0;
      else if (wr_en && wsel == WT_ICR && sub == 3'(g))
        icr_q[g*32 +: 32] <= wdata;
    end
  end

  for (genvar g = 0; g < NLVT; g++) begin : g_lvt
    always_ff @(posedge clk) begin
      if (!rst_n)
        lvt_q[g*32 +: 32] <= LVT_RST;
      else if (wr_en && wsel == WT_LVT && sub == 3'(g))
        lvt_q[g*32 +: 32] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eoi_stb    <= 1'b0;
      tmr_reload <= 1'b0;
    end else begin
      eoi_stb    <= wr_en && (wsel == WT_EOI);
      tmr_reload <= wr_init || (wr_en && wsel == WT_LVT && sub == 3'd0);
    end
  end
endmodule

// File: rtl/lic_regfile.sv
module lic_regfile
  import lic_pkg::*;
#(
  parameter int AW   = 12,
  parameter int NVEC = 256,
  parameter int NLVT = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic [31:0]     wdata,
  input  logic            rd_en,
  input  logic            wr_en,
  output logic [31:0]     rdata,
  input  logic [NVEC-1:0] in_service,
  input  logic [NVEC-1:0] trig_mode,
  input  logic [NVEC-1:0] pending,
  input  logic [31:0]     cur_count,
  output logic            eoi_stb,
  output logic            tmr_reload,
  output logic [31:0]     tmr_lvt,
  output logic [31:0]     tmr_init,
  output logic [3:0]      tmr_div,
  output logic            sv_enable
);
  localparam int IX_LSB = 4;
  localparam int NSLICE = NVEC / WORD_W;
  localparam logic [31:0] VER_WORD = {8'h00, 8'(NLVT - 1), 8'h00, 8'h11};

  logic [7:0]         idx;
  rsel_e              rsel;
  wsel_e              wsel;
  logic [2:0]         sub;
  logic [7:0]         id_q, tpr_q, ppr;
  logic [8:0]         svr_q;
  logic [63:0]        icr_q;
  logic [NLVT*32-1:0] lvt_q;
  logic [31:0]        init_q;
  logic [3:0]         div_q;
  logic               esr_bad;
  logic               bad_acc;
  logic [31:0]        rmux;
  logic [31:0]        rdata_q;
  logic               unused_lsb;

  assign idx        = addr[AW-1:IX_LSB];
  assign unused_lsb = ^addr[IX_LSB-1:0];

  lic_decode #(.NSLICE(NSLICE), .NLVT(NLVT)) u_dec (
    .idx (idx),
    .rsel(rsel),
    .wsel(wsel),
    .sub (sub)
  );

  lic_prio #(.NVEC(NVEC)) u_prio (
    .in_service(in_service),
    .tpr       (tpr_q),
    .ppr       (ppr)
  );

  lic_store #(.NLVT(NLVT)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wsel      (wsel),
    .sub       (sub),
    .wdata     (wdata),
    .id_q      (id_q),
    .tpr_q     (tpr_q),
    .svr_q     (svr_q),
    .icr_q     (icr_q),
    .lvt_q     (lvt_q),
    .init_q    (init_q),
    .div_q     (div_q),
    .eoi_stb   (eoi_stb),
    .tmr_reload(tmr_reload)
  );

  always_comb begin
    unique case (rsel)
      RS_ID:   rmux = {id_q, 24'h0};
      RS_VER:  rmux = VER_WORD;
      RS_TPR:  rmux = {24'h0, tpr_q};
      RS_PPR:  rmux = {24'h0, ppr};
      RS_SVR:  rmux = {23'h0, svr_q};
      RS_ISR:  rmux = in_service[sub*32 +: 32];
      RS_TMR:  rmux = trig_mode[sub*32 +: 32];
      RS_IRR:  rmux = pending[sub*32 +: 32];
      RS_ESR:  rmux = 32'(esr_bad) << ERR_BIT;
      RS_ICR:  rmux = icr_q[sub[0]*32 +: 32];
      RS_LVT:  rmux = lvt_q[sub*32 +: 32];
      RS_INIT: rmux = init_q;
      RS_CUR:  rmux = cur_count;
      RS_DIV:  rmux = {28'h0, div_q};
      default: rmux = '0;
    endcase
  end

  assign bad_acc = (rd_en && rsel == RS_NONE) || (wr_en && wsel == WT_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      esr_bad <= 1'b0;
    end else begin
      if (rd_en)   rdata_q <= rmux;
      if (bad_acc) esr_bad <= 1'b1;
    end
  end

  assign rdata     = rdata_q;
  assign tmr_lvt   = lvt_q[31:0];
  assign tmr_init  = init_q;
  assign tmr_div   = div_q;
  assign sv_enable = svr_q[8];
endmodule

// File: rtl/lic_regfile_chk.sv
module lic_regfile_chk
  import lic_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] addr,
  input logic        rd_en,
  input logic        wr_en,
  input logic [31:0] rdata,
  input logic        eoi_stb,
  input logic        tmr_reload,
  input logic        err_flag
);
  logic [7:0] ix;
  assign ix = addr[11:4];

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R2

  AST_VERSION_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ix == IX_VER) |=> (rdata == 32'h0005_0011)); // R3

  AST_EOI_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ix == IX_EOI) |=> eoi_stb); // R5

  AST_EOI_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || ix != IX_EOI) |=> !eoi_stb); // R5

  AST_RELOAD_ON_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (ix == IX_INIT || ix == IX_LVT)) |=> tmr_reload); // R10

  AST_EOI_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ix == IX_EOI) |=> (rdata == 32'h0 && err_flag)); // R11

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R11
endmodule

bind lic_regfile lic_regfile_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr      (addr),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .rdata     (rdata),
  .eoi_stb   (eoi_stb),
  .tmr_reload(tmr_reload),
  .err_flag  (esr_bad)
);

// File: tb/lic_regfile_test.sv
module lic_regfile_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 256;

  typedef struct packed {
    logic        rd;
    logic        wr;
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] e;
    logic [7:0]  req;
  } vec_t;

  localparam int NT = 31;
  localparam vec_t TBL [NT] = '{
    '{1'b0, 1'b1, 12'h020, 32'hAB00_00FF, 32'h0,         8'd3},  // R3 id write
    '{1'b1, 1'b0, 12'h020, 32'h0,         32'hAB00_0000, 8'd3},  // R3
    '{1'b1, 1'b0, 12'h02C, 32'h0,         32'hAB00_0000, 8'd1},  // R1 low bits ignored
    '{1'b1, 1'b0, 12'h030, 32'h0,         32'h0005_0011, 8'd3},  // R3 version
    '{1'b1, 1'b0, 12'h280, 32'h0,         32'h0,         8'd11}, // R11 clear so far
    '{1'b0, 1'b1, 12'h080, 32'h0000_1230, 32'h0,         8'd4},  // R4
    '{1'b1, 1'b0, 12'h080, 32'h0,         32'h30,        8'd4},  // R4 tpr 8 bits
    '{1'b1, 1'b0, 12'h0A0, 32'h0,         32'h40,        8'd4},  // R4 isr class wins
    '{1'b0, 1'b1, 12'h080, 32'h50,        32'h0,         8'd4},  // R4
    '{1'b1, 1'b0, 12'h0A0, 32'h0,         32'h50,        8'd4},  // R4 tpr wins
    '{1'b0, 1'b1, 12'h0F0, 32'hFFFF_FFFF, 32'h0,         8'd6},  // R6
    '{1'b1, 1'b0, 12'h0F0, 32'h0,         32'h1FF,       8'd6},  // R6 mask
    '{1'b1, 1'b0, 12'h100, 32'h0,         32'h0,         8'd7},  // R7 isr slice 0
    '{1'b1, 1'b0, 12'h120, 32'h0,         32'h20,        8'd7},  // R7 isr slice 2
    '{1'b1, 1'b0, 12'h190, 32'h0,         32'h100,       8'd7},  // R7 tmr slice 1
    '{1'b1, 1'b0, 12'h270, 32'h0,         32'h8000_0000, 8'd7},  // R7 irr slice 7
    '{1'b0, 1'b1, 12'h300, 32'hDEAD_0001, 32'h0,         8'd8},  // R8
    '{1'b1, 1'b0, 12'h300, 32'h0,         32'hDEAD_0001, 8'd8},  // R8 cmd 0
    '{1'b0, 1'b1, 12'h310, 32'h5,         32'h0,         8'd8},  // R8
    '{1'b1, 1'b0, 12'h310, 32'h0,         32'h5,         8'd8},  // R8 cmd 1
    '{1'b0, 1'b1, 12'h370, 32'h0001_00FE, 32'h0,         8'd8},  // R8
    '{1'b1, 1'b0, 12'h370, 32'h0,         32'h0001_00FE, 8'd8},  // R8 entry 5
    '{1'b1, 1'b0, 12'h320, 32'h0,         32'h0001_0000, 8'd8},  // R8 entry 0 reset
    '{1'b0, 1'b1, 12'h3E0, 32'hF,         32'h0,         8'd9},  // R9
    '{1'b1, 1'b0, 12'h3E0, 32'h0,         32'hB,         8'd9},  // R9 mask
    '{1'b1, 1'b0, 12'h390, 32'h0,         32'h1234,      8'd8},  // R8 current count
    '{1'b0, 1'b1, 12'h380, 32'h64,        32'h0,         8'd8},  // R8
    '{1'b1, 1'b0, 12'h380, 32'h0,         32'h64,        8'd8},  // R8 initial count
    '{1'b1, 1'b0, 12'h280, 32'h0,         32'h0,         8'd11}, // R11 still clear
    '{1'b1, 1'b0, 12'h050, 32'h0,         32'h0,         8'd11}, // R11 undefined read
    '{1'b1, 1'b0, 12'h280, 32'h0,         32'h80,        8'd11}  // R11 flag set
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic [11:0]     addr;
  logic [31:0]     wdata;
  logic            rd_en, wr_en;
  logic [31:0]     rdata;
  logic [NVEC-1:0] in_service, trig_mode, pending;
  logic [31:0]     cur_count;
  logic            eoi_stb, tmr_reload, sv_enable;
  logic [31:0]     tmr_lvt, tmr_init;
  logic [3:0]      tmr_div;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lic_regfile uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .rd_en(rd_en), .wr_en(wr_en), .rdata(rdata),
    .in_service(in_service), .trig_mode(trig_mode), .pending(pending),
    .cur_count(cur_count), .eoi_stb(eoi_stb), .tmr_reload(tmr_reload),
    .tmr_lvt(tmr_lvt), .tmr_init(tmr_init), .tmr_div(tmr_div),
    .sv_enable(sv_enable)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one access; returns at the next falling edge, after the capturing rise
  task automatic op(input logic r, input logic w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    rd_en = r; wr_en = w; addr = a; wdata = d;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    in_service = '0; in_service[8'h45] = 1'b1;
    trig_mode  = '0; trig_mode[40] = 1'b1;
    pending    = '0; pending[255] = 1'b1;
    cur_count  = 32'h1234;
    do_reset();

    // Reset state: R2 R6 R8 R9 R11
    chk("R2 rdata reset", rdata, 32'h0);
    chk("R8 tmr_lvt reset", tmr_lvt, 32'h0001_0000);
    chk("R6 sv_enable reset", {31'h0, sv_enable}, 32'h0);
    chk("R9 tmr_div reset", {28'h0, tmr_div}, 32'h0);
    op(1'b1, 1'b0, 12'h0F0, 32'h0);
    chk("R6 svr reset", rdata, 32'hFF);
    for (int k = 0; k < 6; k++) begin
      op(1'b1, 1'b0, 12'h320 + 12'(k * 16), 32'h0);
      chk($sformatf("R8 lvt %0d reset", k), rdata, 32'h0001_0000);
    end

    for (int i = 0; i < NT; i++) begin
      op(TBL[i].rd, TBL[i].wr, TBL[i].a, TBL[i].d);
      if (TBL[i].rd)
        chk($sformatf("R%0d row %0d", TBL[i].req, i), rdata, TBL[i].e);
    end

    // R5: end-of-interrupt pulse, one cycle only
    do_reset();
    op(1'b0, 1'b1, 12'h0B0, 32'h0);
    chk("R5 eoi pulse", {31'h0, eoi_stb}, 32'h1);
    @(negedge clk);
    chk("R5 eoi one cycle", {31'h0, eoi_stb}, 32'h0);
    op(1'b1, 1'b0, 12'h280, 32'h0);
    chk("R5 eoi write is legal", rdata, 32'h0);
    op(1'b1, 1'b0, 12'h0B0, 32'h0);
    chk("R5 eoi read no pulse", {31'h0, eoi_stb}, 32'h0);
    chk("R11 eoi read zero", rdata, 32'h0);
    op(1'b1, 1'b0, 12'h280, 32'h0);
    chk("R11 eoi read flags", rdata, 32'h80);

    // R10: timer reprogram strobe
    do_reset();
    op(1'b0, 1'b1, 12'h330, 32'h0002_0031);
    chk("R10 no reload on entry 1", {31'h0, tmr_reload}, 32'h0);
    op(1'b0, 1'b1, 12'h320, 32'h0002_0030);
    chk("R10 reload on entry 0", {31'h0, tmr_reload}, 32'h1);
    chk("R8 tmr_lvt value", tmr_lvt, 32'h0002_0030);
    @(negedge clk);
    chk("R10 reload one cycle", {31'h0, tmr_reload}, 32'h0);
    op(1'b0, 1'b1, 12'h380, 32'h7);
    chk("R10 reload on count", {31'h0, tmr_reload}, 32'h1);
    chk("R8 tmr_init value", tmr_init, 32'h7);
    op(1'b0, 1'b1, 12'h3E0, 32'h6);
    chk("R9 tmr_div value", {28'h0, tmr_div}, 32'h2);
    op(1'b0, 1'b1, 12'h0F0, 32'h100);
    chk("R6 sv_enable set", {31'h0, sv_enable}, 32'h1);

    // R12: read and write in the same cycle
    op(1'b1, 1'b1, 12'h380, 32'd99);
    chk("R12 read old count", rdata, 32'h7);
    op(1'b1, 1'b0, 12'h380, 32'h0);
    chk("R12 new count stored", rdata, 32'd99);
    op(1'b1, 1'b1, 12'h280, 32'h0);
    chk("R12 read old error", rdata, 32'h0);
    op(1'b1, 1'b0, 12'h280, 32'h0);
    chk("R12 error write flagged", rdata, 32'h80);

    // R2: hold without read
    op(1'b0, 1'b1, 12'h020, 32'h1100_0000);
    repeat (3) @(negedge clk);
    chk("R2 rdata held", rdata, 32'h80);

    // R11: sticky after legal traffic, read-only write flags
    op(1'b1, 1'b0, 12'h020, 32'h0);
    chk("R3 id after write", rdata, 32'h1100_0000);
    op(1'b1, 1'b0, 12'h280, 32'h0);
    chk("R11 sticky", rdata, 32'h80);
    do_reset();
    op(1'b0, 1'b1, 12'h030, 32'hFFFF_FFFF);
    op(1'b1, 1'b0, 12'h280, 32'h0);
    chk("R11 read-only write flags", rdata, 32'h80);
    op(1'b1, 1'b0, 12'h030, 32'h0);
    chk("R3 version unchanged", rdata, 32'h0005_0011);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule